// File: doc/BRIEF.md
# Multithreaded In-Order Issue Scheduler

This block is the issue stage of a core that runs up to eight hardware threads, each strictly in program order. A shared pool of instruction slots is split evenly into one FIFO per thread. Instructions arrive one per cycle, each tagged with a thread number, an optional destination register and up to two optional source registers. They are appended to the tail of their thread's FIFO. Only the oldest instruction of each thread is a candidate for issue.

Operand readiness comes from a per-thread scoreboard that holds one pending bit for each architectural register. Issuing an instruction that writes a register marks that register pending. A writeback clears the bit again. Because results reach the register file late, a head that waits only on a register being written back in the current cycle may still issue in that cycle. The matching operand is then flagged so that it is taken from the forwarding path. No renaming takes place: every register-file address is the thread number placed above the architectural register number.

Each cycle, up to two heads from different threads are granted. Priority rotates, starting just after the most recently granted thread. A flush input empties every queue and clears every scoreboard in a single cycle.

Top module: `mtis_sched`

## Requirements
- R1: After reset, no issue slot is valid, and `in_ready` is high for every thread number presented on `in_tid`.
- R2: Each thread's queue holds SLOTS_PER_THREAD entries (4 by default). While the queue of the thread on `in_tid` is full, `in_ready` is low and an offered instruction is discarded. Other threads still accept.
- R3: Instructions of one thread issue in the order they were inserted. Only the head is examined, so a blocked head holds back every younger instruction of its thread.
- R4: Each issued register address is `{tid, reg}`: the 3-bit thread number in bits 6:4 and the 4-bit architectural register in bits 3:0. This holds for the destination and for both sources.
- R5: Issuing an instruction with its destination enabled marks that register pending for its own thread only. A head with an enabled source or destination that is pending does not issue until a writeback of the same thread and register arrives. A writeback for another thread releases nothing.
- R6: If the only obstacle for a head is a register being written back in the current cycle (same thread and register), the head issues in that cycle and the bypass flag of that source is 1. In every other case the bypass flags are 0.
- R7: At most two instructions issue per cycle, always from different threads. Slot 0 takes the first ready thread after the last granted one, in ascending order with wrap-around, and slot 1 takes the next ready thread. Slot 1 is never valid without slot 0.
- R8: After a cycle with grants, the last granted thread becomes the lowest priority. That thread is the slot 1 thread if slot 1 was valid, otherwise the slot 0 thread.
- R9: In a flush cycle, nothing issues, `in_ready` is low and the offered instruction is discarded. From the next cycle on, all queues are empty and all pending bits are clear.
- R10: An instruction inserted in cycle n is a candidate for issue at the earliest in cycle n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty all queues and clear all scoreboards |
| in_valid | input | 1 | Instruction offered for insertion |
| in_tid | input | 3 | Thread of the offered instruction |
| in_dst_en | input | 1 | Offered instruction writes a register |
| in_dst | input | 4 | Destination architectural register |
| in_sa_en | input | 1 | Source A is used |
| in_sa | input | 4 | Source A architectural register |
| in_sb_en | input | 1 | Source B is used |
| in_sb | input | 4 | Source B architectural register |
| in_ready | output | 1 | Queue of `in_tid` can accept this cycle |
| wb_valid | input | 1 | A result is written back this cycle |
| wb_tid | input | 3 | Thread of the writeback |
| wb_reg | input | 4 | Architectural register of the writeback |
| iss_valid | output | 2 | Per issue slot: instruction granted |
| iss_tid | output | 2x3 | Per slot: thread of the granted instruction |
| iss_dst_en | output | 2 | Per slot: destination used |
| iss_dst_addr | output | 2x7 | Per slot: destination register-file address |
| iss_sa_en | output | 2 | Per slot: source A used |
| iss_sa_addr | output | 2x7 | Per slot: source A register-file address |
| iss_sa_byp | output | 2 | Per slot: source A taken from forwarding |
| iss_sb_en | output | 2 | Per slot: source B used |
| iss_sb_addr | output | 2x7 | Per slot: source B register-file address |
| iss_sb_byp | output | 2 | Per slot: source B taken from forwarding |

## Verification
The checks run on every cycle cover several properties:
- the two slots never name the same thread, and slot 1 is never valid alone;
- a bypass flag appears only while a matching writeback is present;
- an issued destination is never already pending;
- a full queue never shows ready;
- nothing issues in or right after a flush;
- a queue never pops while empty;
- a scoreboard bit that was set shows up on the next cycle.

Other behaviours need the bench's scenarios:
- that each thread keeps its program order;
- that a writeback for a different thread releases nothing;
- that a discarded instruction never appears;
- that the rotating grant order reaches the threads in the exact expected sequence.

// File: rtl/mtis_pkg.sv
package mtis_pkg;
    localparam int unsigned THREADS   = 8;
    localparam int unsigned ARCH_REGS = 16;
    localparam int unsigned ISSUE_W   = 2;
    localparam int unsigned TID_W     = $clog2(THREADS);
    localparam int unsigned REG_W     = $clog2(ARCH_REGS);
    localparam int unsigned PRF_W     = TID_W + REG_W;

    typedef logic [TID_W-1:0] tid_t;
    typedef logic [REG_W-1:0] areg_t;

    typedef struct packed {
        logic  dst_en;
        areg_t dst;
        logic  sa_en;
        areg_t sa;
        logic  sb_en;
        areg_t sb;
    } uop_t;
endpackage

// File: rtl/mtis_fifo.sv
module mtis_fifo
    import mtis_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic push,
    input  uop_t push_uop,
    input  logic pop,
    output logic head_valid,
    output uop_t head_uop,
    output logic full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        uop_t [DEPTH-1:0] slot;
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    always_comb begin
        st_d       = st_q;
        full       = (st_q.cnt == CNT_W'(DEPTH));
        head_valid = (st_q.cnt != '0);
        head_uop   = st_q.slot[st_q.rd];
        do_push    = push && !full;
        do_pop     = pop && head_valid;
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.slot[st_q.wr] = push_uop;
                st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
            end
            if (do_pop) begin
                st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
            end
            st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the issue logic only pops a head that exists
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

    // R2: a full queue with no pop and no flush stays full
    assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !flush) |=> full);

    // R9: a flush leaves the queue empty
    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !head_valid);
endmodule

// File: rtl/mtis_scoreboard.sv
module mtis_scoreboard
    import mtis_pkg::*;
#(
    parameter int unsigned NSET = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               flush,
    input  logic [NSET-1:0]                    set_en,
    input  logic [NSET-1:0][TID_W-1:0]         set_tid,
    input  logic [NSET-1:0][REG_W-1:0]         set_reg,
    input  logic                               clr_en,
    input  logic [TID_W-1:0]                   clr_tid,
    input  logic [REG_W-1:0]                   clr_reg,
    output logic [THREADS-1:0][ARCH_REGS-1:0]  pend
);
    typedef struct packed {
        logic [THREADS-1:0][ARCH_REGS-1:0] bits;
    } sb_st_t;

    sb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.bits = '0;
        end else begin
            if (clr_en) st_d.bits[clr_tid][clr_reg] = 1'b0;
            // a new writer wins over the writeback of an older one
            for (int k = 0; k < int'(NSET); k++) begin
                if (set_en[k]) st_d.bits[set_tid[k]][set_reg[k]] = 1'b1;
            end
        end
        pend = st_q.bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < int'(NSET); k++) begin : g_set_chk
        // R5: a marked destination is pending in the following cycle
        assert_set_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (set_en[k] && !flush) |=> pend[$past(set_tid[k])][$past(set_reg[k])]);
    end

    // R9: flush clears every pending bit
    assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pend == '0));
endmodule

// File: rtl/mtis_rr2.sv
module mtis_rr2 #(
    parameter int unsigned N = 8,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             g0_v,
    output logic [IDX_W-1:0] g0_idx,
    output logic             g1_v,
    output logic [IDX_W-1:0] g1_idx
);
    logic [IDX_W-1:0] cand;

    always_comb begin
        g0_v   = 1'b0;
        g1_v   = 1'b0;
        g0_idx = '0;
        g1_idx = '0;
        cand   = '0;
        for (int unsigned k = 1; k <= N; k++) begin
            cand = IDX_W'((32'(last) + k) % N);
            if (req[cand]) begin
                if (!g0_v) begin
                    g0_v   = 1'b1;
                    g0_idx = cand;
                end else if (!g1_v) begin
                    g1_v   = 1'b1;
                    g1_idx = cand;
                end
            end
        end
    end
endmodule

// File: rtl/mtis_sched.sv
module mtis_sched
    import mtis_pkg::*;
#(
    parameter int unsigned SLOTS_PER_THREAD = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           in_valid,
    input  logic [TID_W-1:0]               in_tid,
    input  logic                           in_dst_en,
    input  logic [REG_W-1:0]               in_dst,
    input  logic                           in_sa_en,
    input  logic [REG_W-1:0]               in_sa,
    input  logic                           in_sb_en,
    input  logic [REG_W-1:0]               in_sb,
    output logic                           in_ready,
    input  logic                           wb_valid,
    input  logic [TID_W-1:0]               wb_tid,
    input  logic [REG_W-1:0]               wb_reg,
    output logic [ISSUE_W-1:0]             iss_valid,
    output logic [ISSUE_W-1:0][TID_W-1:0]  iss_tid,
    output logic [ISSUE_W-1:0]             iss_dst_en,
    output logic [ISSUE_W-1:0][PRF_W-1:0]  iss_dst_addr,
    output logic [ISSUE_W-1:0]             iss_sa_en,
    output logic [ISSUE_W-1:0][PRF_W-1:0]  iss_sa_addr,
    output logic [ISSUE_W-1:0]             iss_sa_byp,
    output logic [ISSUE_W-1:0]             iss_sb_en,
    output logic [ISSUE_W-1:0][PRF_W-1:0]  iss_sb_addr,
    output logic [ISSUE_W-1:0]             iss_sb_byp
);
    typedef struct packed {
        tid_t last;
    } top_st_t;

    top_st_t st_d, st_q;

    uop_t                              in_uop;
    uop_t                              q_head [THREADS];
    uop_t                              iss_uop [ISSUE_W];
    logic [THREADS-1:0]                q_full, q_hv, q_push, q_pop, req;
    logic [THREADS-1:0]                wb_here, sa_blk, sb_blk, dst_blk;
    logic [THREADS-1:0][ARCH_REGS-1:0] pend;
    logic [ISSUE_W-1:0]                g_v;
    tid_t                              g_idx [ISSUE_W];
    logic [ISSUE_W-1:0]                set_en;
    logic [ISSUE_W-1:0][TID_W-1:0]     set_tid;
    logic [ISSUE_W-1:0][REG_W-1:0]     set_reg;

    assign in_uop   = '{dst_en: in_dst_en, dst: in_dst, sa_en: in_sa_en, sa: in_sa,
                        sb_en: in_sb_en, sb: in_sb};
    assign in_ready = !flush && !q_full[in_tid];

    for (genvar t = 0; t < int'(THREADS); t++) begin : g_queue
        assign q_push[t] = in_valid && in_ready && (in_tid == tid_t'(t));
        mtis_fifo #(.DEPTH(SLOTS_PER_THREAD)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .push       (q_push[t]),
            .push_uop   (in_uop),
            .pop        (q_pop[t]),
            .head_valid (q_hv[t]),
            .head_uop   (q_head[t]),
            .full       (q_full[t])
        );
    end

    // head readiness with same-cycle writeback forwarding
    always_comb begin
        for (int t = 0; t < int'(THREADS); t++) begin
            wb_here[t] = wb_valid && !flush && (wb_tid == tid_t'(t));
            sa_blk[t]  = q_head[t].sa_en && pend[t][q_head[t].sa]
                         && !(wb_here[t] && wb_reg == q_head[t].sa);
            sb_blk[t]  = q_head[t].sb_en && pend[t][q_head[t].sb]
                         && !(wb_here[t] && wb_reg == q_head[t].sb);
            dst_blk[t] = q_head[t].dst_en && pend[t][q_head[t].dst]
                         && !(wb_here[t] && wb_reg == q_head[t].dst);
            req[t]     = q_hv[t] && !flush && !sa_blk[t] && !sb_blk[t] && !dst_blk[t];
        end
    end

    mtis_rr2 #(.N(THREADS)) u_pick (
        .req    (req),
        .last   (st_q.last),
        .g0_v   (g_v[0]),
        .g0_idx (g_idx[0]),
        .g1_v   (g_v[1]),
        .g1_idx (g_idx[1])
    );

    always_comb begin
        q_pop = '0;
        for (int k = 0; k < int'(ISSUE_W); k++) begin
            iss_uop[k]      = q_head[g_idx[k]];
            iss_valid[k]    = g_v[k];
            iss_tid[k]      = g_idx[k];
            iss_dst_en[k]   = iss_uop[k].dst_en;
            iss_dst_addr[k] = {g_idx[k], iss_uop[k].dst};
            iss_sa_en[k]    = iss_uop[k].sa_en;
            iss_sa_addr[k]  = {g_idx[k], iss_uop[k].sa};
            iss_sa_byp[k]   = g_v[k] && iss_uop[k].sa_en && pend[g_idx[k]][iss_uop[k].sa];
            iss_sb_en[k]    = iss_uop[k].sb_en;
            iss_sb_addr[k]  = {g_idx[k], iss_uop[k].sb};
            iss_sb_byp[k]   = g_v[k] && iss_uop[k].sb_en && pend[g_idx[k]][iss_uop[k].sb];
            set_en[k]       = g_v[k] && iss_uop[k].dst_en;
            set_tid[k]      = g_idx[k];
            set_reg[k]      = iss_uop[k].dst;
            if (g_v[k]) q_pop[g_idx[k]] = 1'b1;
        end
    end

    mtis_scoreboard #(.NSET(ISSUE_W)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .set_en  (set_en),
        .set_tid (set_tid),
        .set_reg (set_reg),
        .clr_en  (wb_valid),
        .clr_tid (wb_tid),
        .clr_reg (wb_reg),
        .pend    (pend)
    );

    // rotating priority: last granted thread becomes lowest
    always_comb begin
        st_d = st_q;
        if (g_v[1])      st_d.last = g_idx[1];
        else if (g_v[0]) st_d.last = g_idx[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.last <= tid_t'(THREADS - 1);
        else        st_q      <= st_d;
    end

    // R7: slot 1 only alongside slot 0, from a different thread
    assert_slot_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[1] |-> (iss_valid[0] && iss_tid[0] != iss_tid[1]));

    // R2: a full queue never reports ready
    assert_full_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_full[in_tid] |-> !in_ready);

    // R9: no issue in the flush cycle nor the one after
    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (iss_valid == '0 && !in_ready));
    assert_flush_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (iss_valid == '0));

    for (genvar k = 0; k < int'(ISSUE_W); k++) begin : g_iss_chk
        // R6: forwarding flags only while a matching writeback is present
        assert_bypass_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
            iss_sa_byp[k] |-> (wb_valid && wb_tid == iss_tid[k]
                               && wb_reg == iss_sa_addr[k][REG_W-1:0]));
        assert_bypass_srcb_R6: assert property (@(posedge clk) disable iff (!rst_n)
            iss_sb_byp[k] |-> (wb_valid && wb_tid == iss_tid[k]
                               && wb_reg == iss_sb_addr[k][REG_W-1:0]));
        // R5: an issued destination is free or being released now
        assert_dst_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid[k] && iss_dst_en[k]) |->
                (!pend[iss_tid[k]][iss_dst_addr[k][REG_W-1:0]]
                 || (wb_valid && wb_tid == iss_tid[k]
                     && wb_reg == iss_dst_addr[k][REG_W-1:0])));
    end
endmodule

// File: tb/tb_mtis_sched.sv
module tb_mtis_sched;
    import mtis_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    typedef struct packed {
        logic [2:0] tid;
        logic [3:0] dst;
        logic       sa_en;
        logic [3:0] sa;
        logic       sb_en;
        logic [3:0] sb;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 4'd3,  1'b1, 4'd1,  1'b1, 4'd2},
        '{3'd7, 4'd15, 1'b1, 4'd0,  1'b0, 4'd0},
        '{3'd4, 4'd0,  1'b0, 4'd0,  1'b1, 4'd14},
        '{3'd2, 4'd9,  1'b1, 4'd9,  1'b1, 4'd9},
        '{3'd5, 4'd6,  1'b1, 4'd12, 1'b1, 4'd5},
        '{3'd3, 4'd1,  1'b0, 4'd0,  1'b0, 4'd0}
    };

    logic clk = 1'b0;
    logic rst_n, flush, in_valid, in_dst_en, in_sa_en, in_sb_en, in_ready;
    logic [TID_W-1:0] in_tid, wb_tid;
    logic [REG_W-1:0] in_dst, in_sa, in_sb, wb_reg;
    logic wb_valid;
    logic [ISSUE_W-1:0] iss_valid, iss_dst_en, iss_sa_en, iss_sa_byp, iss_sb_en, iss_sb_byp;
    logic [ISSUE_W-1:0][TID_W-1:0] iss_tid;
    logic [ISSUE_W-1:0][PRF_W-1:0] iss_dst_addr, iss_sa_addr, iss_sb_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mtis_sched dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_tid(in_tid), .in_dst_en(in_dst_en), .in_dst(in_dst),
        .in_sa_en(in_sa_en), .in_sa(in_sa), .in_sb_en(in_sb_en), .in_sb(in_sb),
        .in_ready(in_ready),
        .wb_valid(wb_valid), .wb_tid(wb_tid), .wb_reg(wb_reg),
        .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_dst_en(iss_dst_en),
        .iss_dst_addr(iss_dst_addr), .iss_sa_en(iss_sa_en), .iss_sa_addr(iss_sa_addr),
        .iss_sa_byp(iss_sa_byp), .iss_sb_en(iss_sb_en), .iss_sb_addr(iss_sb_addr),
        .iss_sb_byp(iss_sb_byp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input int t, input bit de, input int d, input bit ae, input int a,
                       input bit be, input int b);
        in_valid  = 1'b1;
        in_tid    = TID_W'(t);
        in_dst_en = de;
        in_dst    = REG_W'(d);
        in_sa_en  = ae;
        in_sa     = REG_W'(a);
        in_sb_en  = be;
        in_sb     = REG_W'(b);
    endtask

    task automatic wb(input int t, input int r);
        wb_valid = 1'b1;
        wb_tid   = TID_W'(t);
        wb_reg   = REG_W'(r);
    endtask

    task automatic all_ready(input string req);
        for (int t = 0; t < int'(THREADS); t++) begin
            in_tid = TID_W'(t);
            #1;
            chk(req, 32'(in_ready), 32'd1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; wb_valid = 1'b0;
        in_tid = '0; in_dst_en = 1'b0; in_dst = '0; in_sa_en = 1'b0; in_sa = '0;
        in_sb_en = 1'b0; in_sb = '0; wb_tid = '0; wb_reg = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 idle", 32'(iss_valid), 32'd0);
        all_ready("R1 ready");

        // vector walk: R4 addressing, R10 insert latency, R6 flags idle
        for (int i = 0; i < NVEC; i++) begin
            tick();
            put(VECS[i].tid, 1'b1, VECS[i].dst, VECS[i].sa_en, VECS[i].sa,
                VECS[i].sb_en, VECS[i].sb);
            @(negedge clk);
            chk("R10 no same-cycle issue", 32'(iss_valid), 32'd0);
            tick();
            in_valid = 1'b0;
            @(negedge clk);
            chk("R4 valid", 32'(iss_valid), 32'd1);
            chk("R4 tid", 32'(iss_tid[0]), 32'(VECS[i].tid));
            chk("R4 dst", 32'(iss_dst_addr[0]), 32'({VECS[i].tid, VECS[i].dst}));
            if (VECS[i].sa_en) chk("R4 srca", 32'(iss_sa_addr[0]), 32'({VECS[i].tid, VECS[i].sa}));
            if (VECS[i].sb_en) chk("R4 srcb", 32'(iss_sb_addr[0]), 32'({VECS[i].tid, VECS[i].sb}));
            chk("R6 no bypass", 32'({iss_sa_byp[0], iss_sb_byp[0]}), 32'd0);
            tick();
            wb(VECS[i].tid, VECS[i].dst);
            tick();
            wb_valid = 1'b0;
        end

        // R2/R3/R6: thread 5 fills while blocked on r1
        tick(); put(5, 1'b1, 1, 1'b0, 0, 1'b0, 0);
        tick(); put(5, 1'b0, 0, 1'b1, 1, 1'b1, 2);
        tick(); put(5, 1'b0, 0, 1'b1, 1, 1'b1, 3);
        @(negedge clk);
        chk("R5 source pending blocks", 32'(iss_valid), 32'd0);
        tick(); put(5, 1'b0, 0, 1'b1, 1, 1'b1, 4);
        tick(); put(5, 1'b0, 0, 1'b1, 1, 1'b1, 5);
        tick(); put(5, 1'b0, 0, 1'b1, 1, 1'b1, 6);
        @(negedge clk);
        chk("R2 full stalls", 32'(in_ready), 32'd0);
        tick(); in_valid = 1'b0; in_tid = 3'd2;
        @(negedge clk);
        chk("R2 other thread accepts", 32'(in_ready), 32'd1);
        tick(); wb(5, 1);
        @(negedge clk);
        chk("R6 issue on writeback", 32'(iss_valid), 32'd1);
        chk("R3 order 1", 32'(iss_sb_addr[0]), 32'h52);
        chk("R6 bypass flag", 32'(iss_sa_byp[0]), 32'd1);
        tick(); wb_valid = 1'b0;
        @(negedge clk);
        chk("R3 order 2", 32'(iss_sb_addr[0]), 32'h53);
        chk("R6 flag cleared", 32'(iss_sa_byp[0]), 32'd0);
        tick();
        @(negedge clk);
        chk("R3 order 3", 32'(iss_sb_addr[0]), 32'h54);
        tick();
        @(negedge clk);
        chk("R3 order 4", 32'(iss_sb_addr[0]), 32'h55);
        tick();
        @(negedge clk);
        chk("R2 dropped entry absent", 32'(iss_valid), 32'd0);

        // R5: destination pending blocks, other thread unaffected
        tick(); put(3, 1'b1, 7, 1'b0, 0, 1'b0, 0);
        tick(); put(3, 1'b1, 7, 1'b0, 0, 1'b1, 1);
        tick(); put(4, 1'b0, 0, 1'b1, 7, 1'b1, 9);
        @(negedge clk);
        chk("R5 dst pending blocks", 32'(iss_valid), 32'd0);
        tick(); in_valid = 1'b0;
        @(negedge clk);
        chk("R5 other thread free", 32'(iss_valid), 32'd1);
        chk("R5 other thread tid", 32'(iss_tid[0]), 32'd4);
        chk("R5 other thread srcb", 32'(iss_sb_addr[0]), 32'h49);
        tick(); wb(4, 7);
        @(negedge clk);
        chk("R5 foreign writeback ignored", 32'(iss_valid), 32'd0);
        tick(); wb(3, 7);
        @(negedge clk);
        chk("R5 released", 32'(iss_valid), 32'd1);
        chk("R5 released dst", 32'(iss_dst_addr[0]), 32'h37);
        tick(); wb(3, 7);
        tick(); wb_valid = 1'b0;

        // R7/R8: rotating two-wide selection
        tick(); put(1, 1'b1, 15, 1'b0, 0, 1'b0, 0);
        tick(); put(1, 1'b0, 0, 1'b1, 15, 1'b1, 1);
        tick(); put(1, 1'b0, 0, 1'b0, 0, 1'b1, 2);
        tick(); put(1, 1'b0, 0, 1'b0, 0, 1'b1, 3);
        tick(); put(2, 1'b1, 15, 1'b0, 0, 1'b0, 0);
        tick(); put(2, 1'b0, 0, 1'b1, 15, 1'b1, 4);
        tick(); put(2, 1'b0, 0, 1'b0, 0, 1'b1, 5);
        tick(); put(6, 1'b1, 15, 1'b0, 0, 1'b0, 0);
        tick(); put(6, 1'b0, 0, 1'b1, 15, 1'b1, 6);
        tick(); put(6, 1'b0, 0, 1'b0, 0, 1'b1, 7);
        tick(); in_valid = 1'b0;
        @(negedge clk);
        chk("R3 blocked heads hold", 32'(iss_valid), 32'd0);
        tick(); wb(1, 15);
        @(negedge clk);
        chk("R7 c0 valid", 32'(iss_valid), 32'd1);
        chk("R7 c0 slot0", 32'(iss_sb_addr[0]), 32'h11);
        tick(); wb(2, 15);
        @(negedge clk);
        chk("R7 c1 valid", 32'(iss_valid), 32'd3);
        chk("R8 c1 slot0", 32'(iss_sb_addr[0]), 32'h24);
        chk("R8 c1 slot1", 32'(iss_sb_addr[1]), 32'h12);
        chk("R6 c1 bypass", 32'(iss_sa_byp), 32'd1);
        tick(); wb(6, 15);
        @(negedge clk);
        chk("R7 c2 valid", 32'(iss_valid), 32'd3);
        chk("R8 c2 slot0", 32'(iss_sb_addr[0]), 32'h25);
        chk("R8 c2 slot1", 32'(iss_sb_addr[1]), 32'h66);
        chk("R6 c2 bypass", 32'(iss_sa_byp), 32'd2);
        tick(); wb_valid = 1'b0;
        @(negedge clk);
        chk("R7 c3 valid", 32'(iss_valid), 32'd3);
        chk("R8 c3 wrap slot0", 32'(iss_sb_addr[0]), 32'h13);
        chk("R8 c3 slot1", 32'(iss_sb_addr[1]), 32'h67);
        tick();
        @(negedge clk);
        chk("R7 drained", 32'(iss_valid), 32'd0);

        // R9 flush
        tick(); put(0, 1'b1, 9, 1'b0, 0, 1'b0, 0);
        tick(); put(0, 1'b0, 0, 1'b1, 9, 1'b1, 1);
        tick(); in_valid = 1'b0;
        tick(); flush = 1'b1; put(3, 1'b0, 0, 1'b0, 0, 1'b1, 2);
        @(negedge clk);
        chk("R9 no issue in flush", 32'(iss_valid), 32'd0);
        chk("R9 not ready in flush", 32'(in_ready), 32'd0);
        tick(); flush = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk("R9 queues empty", 32'(iss_valid), 32'd0);
        all_ready("R9 ready after flush");
        tick(); put(0, 1'b0, 0, 1'b1, 9, 1'b1, 8);
        tick(); in_valid = 1'b0;
        @(negedge clk);
        chk("R9 scoreboard cleared", 32'(iss_valid), 32'd1);
        chk("R9 reader addr", 32'(iss_sb_addr[0]), 32'h08);
        chk("R9 reader no bypass", 32'(iss_sa_byp[0]), 32'd0);

        tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule